// File: doc/BRIEF.md
# MPEG Transport Frame Synchronizer

This block sits on a byte stream that arrives one byte per `in_valid` strobe and finds the transport packet framing in it. A sync marker is the value 0x47 or its bit inverse 0xB8. While the block is searching, it counts sync markers that repeat at exactly one packet length. Once that count reaches a programmable acquire threshold, it declares frame lock. While locked, it acts as a flywheel. Only the byte at the expected packet head is examined, and sync values anywhere else are ignored. Lock is given up after a programmable number of consecutive missing markers, and the block then searches again.

Every byte is passed to the output one cycle later. The output carries two flags aligned to the byte it describes: a lock level, and a one-cycle start-of-frame pulse on the first byte of each packet while the block is locked. Software sets both thresholds through a small write port, and it may do so at any time while the stream is running.

Top module: `ts_frame_sync`

## Requirements
- R1: While `rst_n` is low, `frame_lock`, `frame_start` and `out_valid` are 0. The acquire and loss thresholds return to `ACQ_INIT` and `LOSS_INIT`.
- R2: Each byte accepted with `in_valid` = 1 appears on `out_byte`, with `out_valid` = 1, on the next cycle. A cycle with `in_valid` = 0 gives `out_valid` = 0 on the next cycle.
- R3: The bytes 0x47 and 0xB8 are both accepted as sync markers, both during search and at the packet head while locked.
- R4: During search, a marker that arrives exactly `PKT_LEN` strobes after the previous marker adds one to the spacing count. When the count reaches the acquire threshold, `frame_lock` rises in the same output cycle that carries that marker.
- R5: During search, a marker at any other spacing restarts the count at one. If no marker arrives at the expected position, the count returns to zero.
- R6: `frame_start` is high for exactly one output cycle, on the first byte of a packet, and only while lock holds both before and after that byte. It is never high on the marker that completes acquisition.
- R7: While locked, sync values at positions other than the packet head are ignored. A missing marker at the head keeps lock while the count of consecutive misses stays below the loss threshold, and `frame_start` still pulses for that packet.
- R8: A marker at the packet head clears the miss count. When the count of consecutive misses reaches the loss threshold, `frame_lock` falls in the output cycle of the missing byte. No `frame_start` is given for that byte, and the spacing count returns to zero.
- R9: When `cfg_we` = 1, `cfg_data` is written to the acquire threshold (`cfg_sel` = 0) or the loss threshold (`cfg_sel` = 1). The new value applies from the next byte onward. A threshold of 0 behaves as 1.
- R10: Cycles with `in_valid` = 0 advance no counter and leave `frame_lock` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0 selects the acquire threshold, 1 selects the loss threshold |
| cfg_data | input | THR_W | Threshold value to write |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Byte passed through, delayed one cycle |
| frame_lock | output | 1 | Frame lock level, aligned to `out_byte` |
| frame_start | output | 1 | First byte of a packet while locked |

## Verification
On every cycle, the assertions check the local rules. `frame_start` only comes with lock and a valid byte, and it never lasts two cycles. Lock rises only on an output marker and falls only on an output non-marker. Bytes pass through with the right latency, and idle cycles leave the flags alone. Only the bench scenarios can show the counting behaviour: lock on exactly the programmed number of correctly spaced markers, restart on a mis-spaced marker, flywheel tolerance of stray markers and isolated misses, loss on exactly the programmed number of consecutive misses, and runtime threshold writes including zero. The bench sweeps every pair of acquire and loss thresholds in a small range with a short packet.

// File: rtl/ts_frame_sync.sv
module ts_frame_sync #(
  parameter int PKT_LEN   = 204,
  parameter int THR_W     = 4,
  parameter int ACQ_INIT  = 3,
  parameter int LOSS_INIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [THR_W-1:0] cfg_data,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             frame_lock,
  output logic             frame_start
);
  localparam int         IDX_W    = $clog2(PKT_LEN);
  localparam logic [7:0] SYNC_POS = 8'h47;
  localparam logic [7:0] SYNC_NEG = ~SYNC_POS;
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [IDX_W-1:0] idx;
  logic [THR_W-1:0] hits, miss, acq_thr, loss_thr;
  logic             locked;

  wire              is_sync  = (in_byte == SYNC_POS) || (in_byte == SYNC_NEG);
  wire              at_head  = (idx == '0);
  wire              at_last  = (idx == IDX_W'(PKT_LEN - 1));
  wire [IDX_W-1:0]  idx_inc  = at_last ? '0 : idx + 1'b1;
  wire [THR_W-1:0]  hits_nxt = (at_head && hits != '0) ?
                               ((hits == CNT_MAX) ? hits : hits + 1'b1) :
                               THR_W'(1);
  wire [THR_W-1:0]  miss_nxt = (miss == CNT_MAX) ? miss : miss + 1'b1;
  wire              acquire  = !locked && is_sync && (hits_nxt >= acq_thr);
  wire              drop     = locked && at_head && !is_sync && (miss_nxt >= loss_thr);

  assign frame_lock = locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx         <= '0;
      hits        <= '0;
      miss        <= '0;
      locked      <= 1'b0;
      acq_thr     <= THR_W'(ACQ_INIT);
      loss_thr    <= THR_W'(LOSS_INIT);
      out_valid   <= 1'b0;
      out_byte    <= '0;
      frame_start <= 1'b0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel) loss_thr <= cfg_data;
        else         acq_thr  <= cfg_data;
      end
      out_valid   <= in_valid;
      frame_start <= in_valid && locked && at_head && !drop;
      if (in_valid) begin
        out_byte <= in_byte;
        if (locked) begin
          idx <= idx_inc;
          if (at_head) begin
            if (is_sync) begin
              miss <= '0;
            end else if (drop) begin
              locked <= 1'b0;
              miss   <= '0;
              hits   <= '0;
            end else begin
              miss <= miss_nxt;
            end
          end
        end else if (is_sync) begin
          idx  <= IDX_W'(1);
          hits <= hits_nxt;
          if (acquire) begin
            locked <= 1'b1;
            miss   <= '0;
          end
        end else begin
          idx <= idx_inc;
          if (at_head) hits <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ts_frame_sync_chk.sv
module ts_frame_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       frame_lock,
  input logic       frame_start
);
  wire out_is_sync = (out_byte == 8'h47) || (out_byte == 8'hB8);

  assert_pass_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && (out_byte == $past(in_byte)));

  assert_pass_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_lock_on_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_lock) |-> out_valid && out_is_sync);

  assert_start_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> frame_lock && out_valid);

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_drop_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_lock) |-> out_valid && !out_is_sync);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !frame_start && $stable(frame_lock));
endmodule

bind ts_frame_sync ts_frame_sync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .out_valid(out_valid), .out_byte(out_byte),
  .frame_lock(frame_lock), .frame_start(frame_start)
);

// File: tb/ts_frame_sync_bench.sv
module ts_frame_sync_bench;
  localparam int PL = 16;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [TW-1:0] cfg_data = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic          out_valid, frame_lock, frame_start;
  logic [7:0]    out_byte;

  int n_chk = 0, n_bad = 0, n_push = 0;

  always #2 clk = ~clk;

  ts_frame_sync #(.PKT_LEN(PL), .THR_W(TW), .ACQ_INIT(3), .LOSS_INIT(3)) u_ts_frame_sync (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte),
    .frame_lock(frame_lock), .frame_start(frame_start)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input bit el);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R2", "idle out_valid", out_valid, 0);
    chk(frame_start == 1'b0 && frame_lock == el, "R10", "idle flags", {frame_start, frame_lock}, {1'b0, el});
  endtask

  task automatic push(input logic [7:0] b, input bit es, input bit el, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk); #1;
    chk(out_valid == 1'b1 && out_byte == b, "R2", "pass byte", out_byte, b);
    chk(frame_start == es, req, "frame_start", frame_start, es);
    chk(frame_lock == el, req, "frame_lock", frame_lock, el);
    n_push++;
    if (n_push % 7 == 3) idle(el);
  endtask

  task automatic fill(input int n, input bit el, input string req);
    for (int k = 0; k < n; k++) push(8'h20 + 8'(k % 16), 1'b0, el, req);
  endtask

  task automatic cfg(input bit sel, input int v);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we   = 1'b1;
    cfg_sel  = sel;
    cfg_data = TW'(v);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(frame_lock == 0 && frame_start == 0 && out_valid == 0, "R1", "reset outputs",
        {frame_lock, frame_start, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Sweep acquire 1..4 and loss 1..3: R3 R4 R6 R7 R8 R10
    for (int acq = 1; acq <= 4; acq++) begin
      for (int loss = 1; loss <= 3; loss++) begin
        int nf;
        do_reset();
        cfg(1'b0, acq);
        cfg(1'b1, loss);
        nf = acq + loss + 2;
        for (int f = 1; f <= nf; f++) begin
          for (int i = 0; i < PL; i++) begin
            logic [7:0] b;
            bit es, el;
            if (i == 0)
              b = (f <= acq + 1 || f == nf) ? ((f % 2 == 1) ? 8'hB8 : 8'h47) : 8'h00;
            else if (i == 5 && f > acq && f <= acq + loss)
              b = 8'h47;
            else
              b = 8'h10 + 8'(i);
            el = (f >= acq && f <= acq + loss) || (f == nf && acq <= 1);
            es = (i == 0) && (f > acq) && (f <= acq + loss);
            push(b, es, el, (f <= acq) ? "R4" : (f <= acq + loss) ? "R7" : "R8");
          end
        end
      end
    end

    // R5: mis-spaced marker restarts the count
    do_reset();
    cfg(1'b0, 2);
    push(8'h47, 0, 0, "R5");
    fill(5, 0, "R5");
    push(8'hB8, 0, 0, "R5");
    fill(PL - 1, 0, "R5");
    push(8'h47, 0, 1, "R5");
    fill(PL - 1, 1, "R5");
    push(8'hB8, 1, 1, "R3");
    // R5: missing marker at expected spot clears the count
    do_reset();
    cfg(1'b0, 2);
    push(8'h47, 0, 0, "R5");
    fill(PL, 0, "R5");
    push(8'h47, 0, 0, "R5");
    fill(PL - 1, 0, "R5");
    push(8'h47, 0, 1, "R5");

    // R9: zero thresholds act as one, written while running
    do_reset();
    cfg(1'b0, 0);
    push(8'hB8, 0, 1, "R9");
    fill(PL - 1, 1, "R9");
    push(8'h00, 1, 1, "R9");
    cfg(1'b1, 0);
    fill(PL - 1, 1, "R9");
    push(8'h00, 0, 0, "R9");

    // R8: a good marker clears the consecutive miss count
    do_reset();
    cfg(1'b0, 1);
    cfg(1'b1, 2);
    push(8'h47, 0, 1, "R8");
    fill(PL - 1, 1, "R8");
    push(8'h00, 1, 1, "R8");
    fill(PL - 1, 1, "R8");
    push(8'hB8, 1, 1, "R8");
    fill(PL - 1, 1, "R8");
    push(8'h00, 1, 1, "R8");
    fill(PL - 1, 1, "R8");
    push(8'h00, 0, 0, "R8");
    fill(3, 0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule